// File: doc/BRIEF.md
# Display Control Register Bank

This block is the register front end of a simple linear-framebuffer display controller. A host reaches it over a plain register bus that carries a byte address, a write strobe, a read strobe and 32-bit data in each direction. The lower half of the address space is the mode window. Here each 16-bit mode register sits on a halfword boundary, so the register number is the byte address divided by two. Two numbers in this window do not read back what was written. One returns a fixed controller version. The other returns the framebuffer size counted in 64 KiB units. Reads beyond the bank return all ones, and writes there are lost.

The upper half of the address space is a 32-bit extension window. It holds two registers. The first reports the byte length of the window. The second selects the framebuffer byte order and accepts only two magic words. Every mode register is exported as one flat vector, together with the byte-order flag, so that the scan-out and format logic downstream can use them without a read port.

Top module: `dispctl_regbank`

## Requirements
- R1: Address bit ADDR_W-1 low selects the mode window. There, the register number is bits ADDR_W-2..1 of the byte address, and bit 0 is ignored. A write to a number below NUM_REGS stores bus_wdata[15:0] in that slot of `mode_regs` (slot k is bits 16k+15..16k). A read returns the slot zero-extended to 32 bits.
- R2: A read of register number ID_IDX (default 0) returns 0x0000B0C5, whatever was written there. A write to that number is still stored in its `mode_regs` slot.
- R3: A read of register number VMEM_IDX (default 10) returns VRAM_MIB*16, which is the memory size divided by 64 KiB.
- R4: In the mode window, a read of any other number at or above NUM_REGS returns 0xFFFFFFFF. A write there leaves every `mode_regs` slot unchanged.
- R5: Address bit ADDR_W-1 high selects the extension window, where the offset is the low ADDR_W-1 bits. A read at offset 0 returns EXT_BYTES (default 8).
- R6: In the extension window, a read at any offset other than 0 and 4 returns zero. Writes at any offset other than 4 change nothing.
- R7: A write at extension offset 4 sets `fb_big_endian` when the data is 0xBEBEBEBE, and clears it when the data is 0x1E1E1E1E. Any other value leaves it unchanged.
- R8: A read at extension offset 4 returns 0xBEBEBEBE while `fb_big_endian` is 1, and 0x1E1E1E1E while it is 0.
- R9: While rst_n is low, all `mode_regs`, `fb_big_endian` and `bus_rdata` are zero.
- R10: bus_rdata is loaded on the clock edge where bus_rd is high, and holds otherwise. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; top bit selects the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mode_regs | output | NUM_REGS*16 | Flat copy of all mode registers |
| fb_big_endian | output | 1 | Framebuffer byte-order flag, 1 = big-endian |

## Verification
The bench builds the block with its defaults: an 8-bit address, ten mode registers, and 16 MiB of video memory, so the size register reads 256. With the memory-size number at 10, just past the ten-slot bank, the bench can reach the synthesized read at index 10, all-ones reads from 11 through 63, and dropped writes in the same window. The 7-bit extension offset lets it try offsets other than 0 and 4 for zero reads and for writes that are ignored.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

  localparam logic [15:0] ID_WORD  = 16'hB0C5;
  localparam logic [31:0] MAGIC_BE = 32'hBEBE_BEBE;
  localparam logic [31:0] MAGIC_LE = 32'h1E1E_1E1E;

  typedef enum logic [2:0] {
    SRC_BANK,
    SRC_ID,
    SRC_VMEM,
    SRC_ONES,
    SRC_EXT_SIZE,
    SRC_EXT_ORDER,
    SRC_ZERO
  } rd_src_e;

endpackage

// File: rtl/dispctl_addr_dec.sv
module dispctl_addr_dec
  import dispctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_REGS  = 10,
  parameter int ID_IDX    = 0,
  parameter int VMEM_IDX  = 10,
  parameter int SIZE_OFF  = 0,
  parameter int ORDER_OFF = 4,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int OFF_W    = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              bank_hit,
  output logic              order_hit,
  output rd_src_e           src
);

  localparam logic [IDX_W-1:0] ID_I    = IDX_W'(ID_IDX);
  localparam logic [IDX_W-1:0] VMEM_I  = IDX_W'(VMEM_IDX);
  localparam logic [OFF_W-1:0] SIZE_O  = OFF_W'(SIZE_OFF);
  localparam logic [OFF_W-1:0] ORDER_O = OFF_W'(ORDER_OFF);

  logic             ext_sel;
  logic [OFF_W-1:0] off;

  assign ext_sel = addr[ADDR_W-1];
  assign off     = addr[OFF_W-1:0];
  assign idx     = addr[ADDR_W-2:1];

  always_comb begin
    bank_hit  = 1'b0;
    order_hit = 1'b0;
    src       = SRC_ZERO;
    if (ext_sel) begin
      if (off == SIZE_O) begin
        src = SRC_EXT_SIZE;
      end else if (off == ORDER_O) begin
        src       = SRC_EXT_ORDER;
        order_hit = 1'b1;
      end else begin
        src = SRC_ZERO;
      end
    end else begin
      bank_hit = (32'(idx) < NUM_REGS);
      if (idx == ID_I) begin
        src = SRC_ID;
      end else if (idx == VMEM_I) begin
        src = SRC_VMEM;
      end else if (32'(idx) < NUM_REGS) begin
        src = SRC_BANK;
      end else begin
        src = SRC_ONES;
      end
    end
  end

endmodule

// File: rtl/dispctl_mode_bank.sv
module dispctl_mode_bank #(
  parameter int NUM_REGS = 10,
  parameter int IDX_W    = 6,
  localparam int FLAT_W  = NUM_REGS * 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              bank_hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [15:0]       wdata,
  output logic [FLAT_W-1:0] regs_flat,
  output logic [15:0]       rd_word
);

  logic [NUM_REGS-1:0] slot_we;
  logic [FLAT_W-1:0]   regs_d;
  logic [FLAT_W-1:0]   regs_q;

  // Per-slot write enable: only a write that decodes inside the bank lands.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot_we
    assign slot_we[i] = wr_req && bank_hit && (idx == IDX_W'(i));
  end

  always_comb begin
    regs_d = regs_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (slot_we[i]) begin
        regs_d[i*16 +: 16] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (|slot_we) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_word = regs_q[i*16 +: 16];
      end
    end
  end

  assign regs_flat = regs_q;

  // R4: a write decoded outside the bank must not disturb any slot
  p_oob_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !bank_hit) |=> $stable(regs_flat));

  // R1: an in-bank write is visible in the addressed slot on the next cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && bank_hit && idx == '0) |=> (regs_flat[15:0] == $past(wdata)));

endmodule

// File: rtl/dispctl_ext_regs.sv
module dispctl_ext_regs
  import dispctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_order,
  input  logic [31:0] wdata,
  output logic        be_flag,
  output logic [31:0] order_word
);

  logic is_be;
  logic is_le;
  logic flag_en;
  logic flag_d;
  logic flag_q;

  assign is_be   = (wdata == MAGIC_BE);
  assign is_le   = (wdata == MAGIC_LE);
  assign flag_en = wr_order && (is_be || is_le);
  assign flag_d  = is_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign be_flag    = flag_q;
  assign order_word = flag_q ? MAGIC_BE : MAGIC_LE;

  // R7: unrecognized values leave the flag alone
  p_order_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_order && wdata != MAGIC_BE && wdata != MAGIC_LE) |=> $stable(be_flag));

  // R7: big-endian magic sets the flag
  p_order_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_order && wdata == MAGIC_BE) |=> be_flag);

  // R7: little-endian magic clears the flag
  p_order_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_order && wdata == MAGIC_LE) |=> !be_flag);

endmodule

// File: rtl/dispctl_regbank.sv
module dispctl_regbank
  import dispctl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_REGS  = 10,
  parameter int ID_IDX    = 0,
  parameter int VMEM_IDX  = 10,
  parameter int VRAM_MIB  = 16,
  parameter int EXT_BYTES = 8,
  localparam int IDX_W    = ADDR_W - 2,
  localparam int FLAT_W   = NUM_REGS * 16,
  localparam int VMEM_64K = VRAM_MIB * 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [FLAT_W-1:0] mode_regs,
  output logic              fb_big_endian
);

  logic [IDX_W-1:0] idx;
  logic             bank_hit;
  logic             order_hit;
  rd_src_e          src;
  logic [15:0]      bank_word;
  logic [31:0]      order_word;
  logic [31:0]      rdata_d;
  logic [31:0]      rdata_q;

  dispctl_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .ID_IDX   (ID_IDX),
    .VMEM_IDX (VMEM_IDX),
    .SIZE_OFF (0),
    .ORDER_OFF(4)
  ) u_dec (
    .addr     (bus_addr),
    .idx      (idx),
    .bank_hit (bank_hit),
    .order_hit(order_hit),
    .src      (src)
  );

  dispctl_mode_bank #(
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (bus_wr),
    .bank_hit (bank_hit),
    .idx      (idx),
    .wdata    (bus_wdata[15:0]),
    .regs_flat(mode_regs),
    .rd_word  (bank_word)
  );

  dispctl_ext_regs u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_order  (bus_wr && order_hit),
    .wdata     (bus_wdata),
    .be_flag   (fb_big_endian),
    .order_word(order_word)
  );

  always_comb begin
    unique case (src)
      SRC_BANK:      rdata_d = {16'h0000, bank_word};
      SRC_ID:        rdata_d = {16'h0000, ID_WORD};
      SRC_VMEM:      rdata_d = 32'(VMEM_64K);
      SRC_ONES:      rdata_d = 32'hFFFF_FFFF;
      SRC_EXT_SIZE:  rdata_d = 32'(EXT_BYTES);
      SRC_EXT_ORDER: rdata_d = order_word;
      default:       rdata_d = 32'h0000_0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  // R10: read data holds on cycles without a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R2: the identification number always reads the version constant
  p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr[ADDR_W-1] && bus_addr[ADDR_W-2:1] == IDX_W'(ID_IDX))
      |=> (bus_rdata == 32'h0000_B0C5));

  // R4: reads beyond the bank (other than the size number) return all ones
  p_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr[ADDR_W-1] && 32'(bus_addr[ADDR_W-2:1]) >= NUM_REGS
       && bus_addr[ADDR_W-2:1] != IDX_W'(VMEM_IDX))
      |=> (bus_rdata == 32'hFFFF_FFFF));

  // R8: order read reflects the flag from before the edge
  p_order_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && order_hit && fb_big_endian) |=> (bus_rdata == 32'hBEBE_BEBE));

endmodule

// File: tb/dispctl_regbank_tb.sv
`timescale 1ns/1ps
module dispctl_regbank_tb_top;

  localparam int NREG = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NREG*16-1:0] mode_regs;
  logic        fb_big_endian;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int unsigned m_regs [NREG];
  bit          m_be;
  int unsigned m_rdata;

  always #2.5 clk = ~clk;

  dispctl_regbank dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .mode_regs    (mode_regs),
    .fb_big_endian(fb_big_endian)
  );

  function automatic int unsigned model_read(int unsigned a);
    int unsigned off;
    int unsigned num;
    off = a % 128;
    if (a >= 128) begin
      if (off == 0) return 8;
      if (off == 4) return m_be ? 32'hBEBEBEBE : 32'h1E1E1E1E;
      return 0;
    end
    num = off / 2;
    if (num == 0)  return 32'h0000B0C5;
    if (num == 10) return 256;
    if (num < NREG) return m_regs[num];
    return 32'hFFFFFFFF;
  endfunction

  task automatic model_write(int unsigned a, int unsigned d);
    int unsigned num;
    if (a >= 128) begin
      if ((a % 128) == 4) begin
        if (d == 32'hBEBEBEBE) m_be = 1'b1;
        else if (d == 32'h1E1E1E1E) m_be = 1'b0;
      end
    end else begin
      num = a / 2;
      if (num < NREG) m_regs[num] = d & 32'hFFFF;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, bus_rdata, m_rdata, "rdata");
    check(req, {31'd0, fb_big_endian}, {31'd0, m_be}, "byte_order");
    for (int i = 0; i < NREG; i++) begin
      check(req, {16'd0, mode_regs[i*16 +: 16]}, m_regs[i], "mode_slot");
    end
  endtask

  task automatic step(string req, int unsigned a, bit wr, int unsigned d, bit rd);
    bus_addr = a[7:0]; bus_wr = wr; bus_wdata = d; bus_rd = rd;
    @(posedge clk);
    if (rd) m_rdata = model_read(a);
    if (wr) model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    compare_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) m_regs[i] = 0;
    m_be = 1'b0; m_rdata = 0;
    #1;
    compare_all("R9");
    @(negedge clk);
    compare_all("R9");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    do_reset();
    // R1: write and read back each bank slot, odd byte addresses alias
    for (int i = 1; i < NREG; i++) step("R1", 2*i, 1, 32'hA500_0000 | (i * 32'h1111), 0);
    for (int i = 1; i < NREG; i++) step("R1", 2*i + (i % 2), 0, 0, 1);
    step("R1", 7, 1, 32'h0000_7E57, 1);
    step("R1", 6, 0, 0, 1);
    // R2: version constant regardless of stored value
    step("R2", 0, 1, 32'h0000_1234, 0);
    step("R2", 0, 0, 0, 1);
    check("R2", bus_rdata, 32'h0000B0C5, "id_read");
    check("R2", {16'd0, mode_regs[15:0]}, 32'h1234, "id_slot_stored");
    // R3: memory size in 64 KiB units
    step("R3", 20, 0, 0, 1);
    check("R3", bus_rdata, 32'd256, "vmem_read");
    step("R3", 20, 1, 32'h0000_FFFF, 1);
    // R4: out-of-range reads and dropped writes
    step("R4", 22, 0, 0, 1);
    check("R4", bus_rdata, 32'hFFFFFFFF, "oob_read");
    step("R4", 126, 1, 32'h0000_DEAD, 1);
    step("R4", 40, 1, 32'h0000_BEEF, 0);
    // R5 / R8: extension size and order at reset
    step("R5", 128, 0, 0, 1);
    check("R5", bus_rdata, 32'd8, "ext_size");
    step("R8", 132, 0, 0, 1);
    check("R8", bus_rdata, 32'h1E1E1E1E, "order_le");
    // R7: magic writes
    step("R7", 132, 1, 32'hBEBEBEBE, 0);
    check("R7", {31'd0, fb_big_endian}, 32'd1, "set_be");
    step("R8", 132, 0, 0, 1);
    check("R8", bus_rdata, 32'hBEBEBEBE, "order_be");
    step("R7", 132, 1, 32'h1234_5678, 0);
    step("R7", 132, 1, 32'hBEBEBEBF, 0);
    check("R7", {31'd0, fb_big_endian}, 32'd1, "keep_be");
    step("R7", 132, 1, 32'h1E1E1E1E, 0);
    check("R7", {31'd0, fb_big_endian}, 32'd0, "clear_be");
    step("R7", 132, 1, 32'h0000_0000, 0);
    // R6: other extension offsets
    step("R6", 136, 1, 32'hBEBEBEBE, 1);
    step("R6", 133, 1, 32'hBEBEBEBE, 1);
    step("R6", 128, 1, 32'hBEBEBEBE, 0);
    step("R6", 255, 0, 0, 1);
    check("R6", bus_rdata, 32'd0, "ext_zero");
    step("R6", 128, 0, 0, 1);
    // R10: read with write in same cycle returns prior value; hold without read
    step("R10", 4, 1, 32'h0000_C0DE, 1);
    step("R10", 4, 0, 0, 0);
    step("R10", 132, 1, 32'hBEBEBEBE, 1);
    check("R10", bus_rdata, 32'h1E1E1E1E, "read_before_write");
    step("R10", 22, 0, 0, 0);
    step("R10", 2, 0, 0, 1);
    // R9: reset in the middle of activity
    do_reset();
    step("R9", 132, 0, 0, 1);
    step("R9", 2, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule